// File: doc/BRIEF.md
# Level-Tracking Interrupt Controller

This block gathers up to 32 interrupt sources into a status word. It gates that word with an enable word and drives a single interrupt request to the processor. Each source owns one status bit, the bit at value `1 << i` for source `i`. The bit is set when the source is seen to rise and cleared when the source is seen to fall. Between those events software may clear the bit or overwrite it. Where peripherals are numbered from the most significant end, a peripheral at big-endian position `p` lands on status bit `31 - p`.

Software reaches four word-aligned registers over a simple single-cycle bus:
- a status register that reads the raw status and clears bits written as one;
- a status-set register that replaces the whole status word;
- an enable register;
- a read-only masked view.

The request output is registered. It follows whether any enabled status bit is set.

Top module: `lvl_irq_hub`

## Requirements
- R1: After synchronous reset, status and enable are zero, `irq_o` is low and `bus_rdata` is zero.
- R2: A source input going from 0 to 1 (sampled on the clock edge) sets its status bit `i` (value `1 << i`) at that edge.
- R3: A source input going from 1 to 0 clears its status bit at that edge. A source that holds its level changes nothing.
- R4: `irq_o` is high in the cycle after the status/enable registers hold a nonzero AND, and low in the cycle after that AND is zero.
- R5: A write to offset 0x0 clears every status bit whose write-data bit is 1 and leaves the others alone. A read of 0x0 returns the raw status.
- R6: A write to offset 0x4 replaces the entire status word with the write data. A read of 0x4 returns the raw status.
- R7: Offset 0x8 holds the enable word, readable and writable. A new value takes effect on `irq_o` one cycle after it is stored.
- R8: A read of offset 0xC returns status AND enable. A write to 0xC changes neither status nor enable.
- R9: Any offset other than 0x0, 0x4, 0x8 or 0xC (including unaligned ones) reads as zero, and a write to it has no effect.
- R10: When a bus write to 0x0 (with that data bit 1) or to 0x4 targets a status bit in the same cycle as a source event on that bit, the write decides the bit.
- R11: Read data appears on `bus_rdata` in the cycle after the read request and shows the state before that edge. `bus_rdata` is zero after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt source levels, one per status bit |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The sources are first driven with isolated rises and falls on the lowest, a middle and the highest bit. This separates set-on-rise from clear-on-fall and catches bit-index mistakes. Enable patterns that do and do not overlap the pending bits separate the gating from the raw status. Bus writes that land in the same cycle as a source event on the same bit show the priority order. A long pseudo-random stretch mixes source toggling with accesses to every offset, mapped and unmapped, and is compared each cycle against a behavioural model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_SET  = 4;
  localparam int unsigned OFS_EN   = 8;
  localparam int unsigned OFS_MSK  = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_SET,
    SEL_EN,
    SEL_MSK
  } reg_sel_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    reg_sel_e sel;
  } bus_op_t;

  // Map a big-endian bit position to the little-endian status index.
  function automatic int unsigned be_to_lsb(input int unsigned be_pos,
                                            input int unsigned width);
    return width - 1 - be_pos;
  endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_op_t           op
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MSK);

  always_comb begin
    op.rd  = bus_sel & ~bus_we;
    op.wr  = bus_sel & bus_we;
    op.sel = SEL_NONE;
    if (bus_sel) begin
      if (bus_addr == A_STAT)     op.sel = SEL_STAT;
      else if (bus_addr == A_SET) op.sel = SEL_SET;
      else if (bus_addr == A_EN)  op.sel = SEL_EN;
      else if (bus_addr == A_MSK) op.sel = SEL_MSK;
      else                        op.sel = SEL_NONE;
    end
  end

endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  bus_op_t           op,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_SRC-1:0]  stat_q
);

  logic [N_SRC-1:0] src_q;
  logic             clr_we;
  logic             set_we;

  assign clr_we = op.wr && (op.sel == SEL_STAT);
  assign set_we = op.wr && (op.sel == SEL_SET);

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic rise;
    logic fall;
    assign rise = src_i[i] & ~src_q[i];
    assign fall = ~src_i[i] & src_q[i];

    // Bus writes outrank source events on the same bit.
    always_ff @(posedge clk) begin
      if (rst)                       stat_q[i] <= 1'b0;
      else if (set_we)               stat_q[i] <= wdata[i];
      else if (clr_we && wdata[i])   stat_q[i] <= 1'b0;
      else if (rise)                 stat_q[i] <= 1'b1;
      else if (fall)                 stat_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/irqc_enable.sv
module irqc_enable
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_t           op,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_SRC-1:0]  en_q
);

  always_ff @(posedge clk) begin
    if (rst)                                en_q <= '0;
    else if (op.wr && (op.sel == SEL_EN))   en_q <= wdata[N_SRC-1:0];
  end

endmodule

// File: rtl/irqc_readout.sv
module irqc_readout
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_t           op,
  input  logic [N_SRC-1:0]  stat,
  input  logic [N_SRC-1:0]  en,
  output logic [DATA_W-1:0] rdata_q,
  output logic              irq_q
);

  logic [N_SRC-1:0]  masked;
  logic [DATA_W-1:0] mux;

  assign masked = stat & en;

  always_comb begin
    unique case (op.sel)
      SEL_STAT: mux = DATA_W'(stat);
      SEL_SET:  mux = DATA_W'(stat);
      SEL_EN:   mux = DATA_W'(en);
      SEL_MSK:  mux = DATA_W'(masked);
      default:  mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= op.rd ? mux : '0;
      irq_q   <= |masked;
    end
  end

endmodule

// File: rtl/lvl_irq_hub.sv
module lvl_irq_hub
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  bus_op_t          op;
  logic [N_SRC-1:0] stat_q;
  logic [N_SRC-1:0] en_q;

  irqc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .op       (op)
  );

  irqc_status #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_status (
    .clk    (clk),
    .rst    (rst),
    .src_i  (src_i),
    .op     (op),
    .wdata  (bus_wdata),
    .stat_q (stat_q)
  );

  irqc_enable #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_enable (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .wdata (bus_wdata),
    .en_q  (en_q)
  );

  irqc_readout #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_readout (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .stat    (stat_q),
    .en      (en_q),
    .rdata_q (bus_rdata),
    .irq_q   (irq_o)
  );

endmodule

// File: rtl/lvl_irq_hub_chk.sv
module lvl_irq_hub_chk
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_o,
  input logic [N_SRC-1:0]  stat_q,
  input logic [N_SRC-1:0]  en_q
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(OFS_MSK);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && bus_rdata == '0));  // R1

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == $past(|(stat_q & en_q))));  // R4

  AST_CLR_ONES: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == A_STAT) |=> ((stat_q & $past(bus_wdata[N_SRC-1:0])) == '0));  // R5

  AST_SET_REPLACE: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == A_SET) |=> (stat_q == $past(bus_wdata[N_SRC-1:0])));  // R6

  AST_EN_STORE: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == A_EN) |=> (en_q == $past(bus_wdata[N_SRC-1:0])));  // R7

  AST_MSK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == A_MSK) |=> $stable(en_q));  // R8

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0));  // R11

endmodule

bind lvl_irq_hub lvl_irq_hub_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .stat_q    (stat_q),
  .en_q      (en_q)
);

// File: tb/tb_lvl_irq_hub.sv
`timescale 1ns/1ps
module tb_lvl_irq_hub;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_i;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;

  always #2.5 clk = ~clk;

  lvl_irq_hub dut (
    .clk(clk), .rst(rst), .src_i(src_i),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";

  // Behavioural reference state
  logic [31:0] m_stat = '0, m_en = '0, m_prev = '0, m_rd = '0;
  logic        m_irq = 1'b0;

  task automatic compare();
    n_tests++;
    if (bus_rdata !== m_rd) begin
      n_fail++;
      $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata, m_rd, $time);
    end
    n_tests++;
    if (irq_o !== m_irq) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b t=%0t", cur_req, irq_o, m_irq, $time);
    end
  endtask

  task automatic model_edge();
    logic [31:0] rise, fall, nxt, rd;
    rd = 32'h0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        4'h0, 4'h4: rd = m_stat;
        4'h8:       rd = m_en;
        4'hC:       rd = m_stat & m_en;
        default:    rd = 32'h0;
      endcase
    end
    m_irq = ((m_stat & m_en) != 0);
    m_rd  = rd;
    rise  = src_i & ~m_prev;
    fall  = ~src_i & m_prev;
    nxt   = (m_stat | rise) & ~fall;
    if (bus_sel && bus_we && bus_addr == 4'h0) nxt = nxt & ~bus_wdata;
    if (bus_sel && bus_we && bus_addr == 4'h4) nxt = bus_wdata;
    if (bus_sel && bus_we && bus_addr == 4'h8) m_en = bus_wdata;
    m_stat = nxt;
    m_prev = src_i;
  endtask

  // Drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input logic s, input logic w, input logic [3:0] a,
                      input logic [31:0] d, input logic [31:0] sr);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; src_i = sr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] sr);
    step(1'b1, 1'b0, a, 32'h0, sr);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [31:0] sr);
    step(1'b1, 1'b1, a, d, sr);
  endtask

  task automatic idle(input logic [31:0] sr);
    step(1'b0, 1'b0, 4'h0, 32'h0, sr);
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] src;
    rst = 1'b1; src_i = '0; bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_req = "R1"; compare();
    rd(4'h0, 0); rd(4'h8, 0); idle(0);

    // R2: single rises on low, middle, high bits
    cur_req = "R2";
    src = 32'h0000_0001; idle(src); rd(4'h0, src);
    src = 32'h0000_0021; idle(src); rd(4'h0, src);
    src = 32'h8000_0021; idle(src); rd(4'h0, src); idle(src);

    // R7 / R4: enable subset, request rises a cycle later
    cur_req = "R7"; wr(4'h8, 32'h8000_0020, src); rd(4'h8, src);
    cur_req = "R4"; idle(src); idle(src);
    cur_req = "R8"; rd(4'hC, src);

    // R3: falls clear bits; request drops once no enabled bit remains
    cur_req = "R3";
    src = 32'h8000_0001; idle(src); rd(4'h0, src);
    src = 32'h0000_0001; idle(src); rd(4'h0, src);
    cur_req = "R4"; idle(src); idle(src);

    // R5: clear-by-ones while sources stay high
    cur_req = "R5";
    src = 32'h0000_FF01; idle(src); rd(4'h0, src);
    wr(4'h0, 32'h0000_0F00, src); rd(4'h0, src);
    wr(4'h0, 32'h0000_0000, src); rd(4'h0, src);

    // R6: whole-word replace and readback through 0x4
    cur_req = "R6";
    wr(4'h4, 32'hA5A5_0000, src); rd(4'h4, src); rd(4'h0, src);
    wr(4'h8, 32'hFFFF_FFFF, src); idle(src); idle(src);
    wr(4'h4, 32'h0, src); idle(src); idle(src);

    // R8: masked view, writes there ignored
    cur_req = "R8";
    wr(4'h4, 32'h1234_5678, src); wr(4'h8, 32'h0F0F_0F0F, src); rd(4'hC, src);
    wr(4'hC, 32'hFFFF_FFFF, src); rd(4'h8, src); rd(4'h0, src);

    // R9: unmapped and unaligned offsets
    cur_req = "R9";
    wr(4'h1, 32'hFFFF_FFFF, src); wr(4'h5, 32'hFFFF_FFFF, src); wr(4'hE, 32'h0, src);
    rd(4'h0, src); rd(4'h8, src); rd(4'h2, src); rd(4'h9, src); rd(4'hF, src);

    // R10: same-cycle write versus source event on the same bit
    cur_req = "R10";
    src = 32'h0; idle(src); wr(4'h4, 32'h0, src);
    src = 32'h0000_0008; wr(4'h0, 32'h0000_0008, src); rd(4'h0, src);
    src = 32'h0; wr(4'h4, 32'h0000_0008, src); rd(4'h0, src);
    src = 32'h0000_0010; wr(4'h4, 32'h0, src); rd(4'h0, src);

    // R11: read data lag and zero on non-read cycles
    cur_req = "R11";
    rd(4'h8, src); wr(4'h8, 32'h0000_00FF, src); idle(src); rd(4'h8, src); idle(src);

    // Mixed pseudo-random traffic
    cur_req = "R4";
    lfsr = 32'hACE1_1357;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[4]) src = src ^ (32'h1 << lfsr[12:8]);
      step(lfsr[5] | lfsr[6], lfsr[7], lfsr[19:16], {lfsr[15:0], lfsr[31:16]}, src);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule